// File: doc/BRIEF.md
# Half to single precision float widener

This block turns a 16-bit half-precision floating-point bit pattern into the 32-bit single-precision bit pattern of the same value. Every half value can be written exactly in single precision, so the conversion never rounds and needs no arithmetic unit. The work is field handling: the exponent is re-biased, the mantissa is moved to the top of the wider field, and subnormal inputs are normalised by counting leading zeros and shifting left.

A one-bit mode input picks how the largest half exponent is read. In standard mode it marks infinity or NaN, and the output carries the maximum single exponent. In extended-range mode it is an ordinary finite value, and the output exponent follows the same re-biasing rule as any other normal number. The block streams one conversion per cycle with a valid flag and no back-pressure. A parameter chooses a registered output, which gives one cycle of latency, or a purely combinational path.

Top module: `half_to_single_widener`

## Requirements
- R1: For an input exponent field (bits 14:10) from 1 to 30, the output exponent (bits 30:23) is the input exponent plus 112. The output mantissa bits 22:13 are the input bits 9:0 and bits 12:0 are zero. The same holds for exponent 31 when mode=1.
- R2: For an input with exponent 0 and a nonzero mantissa, let s be one more than the number of leading zeros of the 10-bit mantissa (1 to 10). The output exponent is 113 minus s, so the smallest subnormal gives 0x67. The output mantissa bits 22:13 are the low 10 bits of the input mantissa shifted left by s, and bits 12:0 are zero.
- R3: An input whose bits 14:0 are all zero gives output bits 30:0 all zero, for either sign.
- R4: With mode=0 (standard), input exponent 31 gives output exponent 0xFF and carries input bits 9:0 into output bits 22:13, with bits 12:0 zero. Infinity stays infinity and NaN stays NaN.
- R5: With mode=1 (extended range), input exponent 31 gives output exponent 0x8F, which is finite, and never gives exponent 0xFF.
- R6: Output bit 31 equals input bit 15 for every conversion.
- R7: With REG_OUT=1, out_valid in a cycle equals in_valid at the previous rising edge, and out_bits carries that edge's conversion. When in_valid was low, out_bits keeps its previous value.
- R8: While rst_n is low at a rising edge (synchronous, active low), out_valid and out_bits are cleared to zero, whatever in_valid is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pattern is present |
| in_bits | input | 16 | Half-precision bit pattern |
| mode | input | 1 | 0 = standard (exponent 31 is Inf/NaN), 1 = extended range |
| out_valid | output | 1 | Result is present |
| out_bits | output | 32 | Single-precision bit pattern |

## Verification
On every accepted input, the assertions check that the sign is copied, that zero collapses to an all-zero magnitude, that the exponent of a normal input is re-biased, and that the top input exponent goes to 0xFF or 0x8F according to mode with its mantissa carried. They also check the one-cycle valid timing. The subnormal results depend on a leading-zero search and a data-dependent shift, and no short property captures them. Only the bench shows them, by sweeping all 65536 patterns in both modes against a reference that normalises with a step-by-step loop. The bench's scenarios alone also show the reset clearing, and that out_bits holds its value across cycles with no input.

// File: rtl/half_widen_pkg.sv
// Package: shared classification and mode types for the half-to-single widener.
// Assumes nothing beyond standard binary floating-point field layouts.
package half_widen_pkg;

    // Interpretation of the largest half exponent.
    typedef enum logic {
        MODE_STANDARD = 1'b0,   // exponent all-ones means Inf/NaN
        MODE_EXTENDED = 1'b1    // exponent all-ones is a finite value
    } widen_mode_e;

    // Input class that decides how the output fields are built.
    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } half_class_e;

endpackage

// File: rtl/hw_lead_zero_count.sv
// Module: counts the leading zeros of a vector, from its most significant bit.
// Assumes WIDTH >= 1. An all-zero vector reports WIDTH.
module hw_lead_zero_count #(
    parameter int WIDTH = 10,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] count
);

    // Scan from LSB upward; the last set bit seen is the highest one.
    always_comb begin
        count = CNT_W'(WIDTH);
        for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) count = CNT_W'(WIDTH - 1 - i);
        end
    end

endmodule

// File: rtl/hw_subnorm_normalizer.sv
// Module: normalises a subnormal mantissa by shifting its leading one out
// into the hidden position. Reports the shift used (leading zeros + 1).
// Assumes the mantissa is nonzero when the result is used.
module hw_subnorm_normalizer #(
    parameter int MAN_W = 10,
    localparam int SH_W = $clog2(MAN_W + 1)
) (
    input  logic [MAN_W-1:0] man_in,
    output logic [SH_W-1:0]  shift,
    output logic [MAN_W-1:0] man_out
);

    logic [SH_W-1:0] lead_zeros;

    hw_lead_zero_count #(.WIDTH(MAN_W)) u_lzc (
        .vec   (man_in),
        .count (lead_zeros)
    );

    // Shift one past the leading zeros so the leading one leaves the field.
    always_comb begin
        shift   = lead_zeros + SH_W'(1);
        man_out = man_in << shift;
    end

endmodule

// File: rtl/hw_half_widen_core.sv
// Module: combinational field conversion from half to single precision.
// Classifies the input, re-biases the exponent, normalises subnormals and
// widens the mantissa. Exact by construction; no rounding is needed.
// Assumes SGL_EXP_W > HALF_EXP_W and SGL_MAN_W >= HALF_MAN_W.
module hw_half_widen_core
    import half_widen_pkg::*;
#(
    parameter int HALF_EXP_W = 5,
    parameter int HALF_MAN_W = 10,
    parameter int SGL_EXP_W  = 8,
    parameter int SGL_MAN_W  = 23,
    localparam int HALF_W    = 1 + HALF_EXP_W + HALF_MAN_W,
    localparam int SGL_W     = 1 + SGL_EXP_W + SGL_MAN_W
) (
    input  logic              mode,
    input  logic [HALF_W-1:0] half_in,
    output logic [SGL_W-1:0]  single_out
);

    localparam int HALF_BIAS = (1 << (HALF_EXP_W - 1)) - 1;
    localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int EXP_ADJ   = SGL_BIAS - HALF_BIAS;
    localparam int PAD_W     = SGL_MAN_W - HALF_MAN_W;
    localparam int SH_W      = $clog2(HALF_MAN_W + 1);

    logic                  sgn;
    logic [HALF_EXP_W-1:0] h_exp;
    logic [HALF_MAN_W-1:0] h_man;
    half_class_e           cls;
    logic [SH_W-1:0]       sub_shift;
    logic [HALF_MAN_W-1:0] sub_man;
    logic [SGL_EXP_W-1:0]  o_exp;
    logic [HALF_MAN_W-1:0] o_man;

    // Split the input pattern into its fields.
    always_comb begin
        sgn   = half_in[HALF_W-1];
        h_exp = half_in[HALF_W-2 -: HALF_EXP_W];
        h_man = half_in[HALF_MAN_W-1:0];
    end

    hw_subnorm_normalizer #(.MAN_W(HALF_MAN_W)) u_norm (
        .man_in  (h_man),
        .shift   (sub_shift),
        .man_out (sub_man)
    );

    // Classify the input; the top exponent is special only in standard mode.
    always_comb begin
        if (h_exp == '0)
            cls = (h_man == '0) ? CLS_ZERO : CLS_SUBNORM;
        else if (&h_exp && widen_mode_e'(mode) == MODE_STANDARD)
            cls = CLS_SPECIAL;
        else
            cls = CLS_NORMAL;
    end

    // Build the output exponent and upper mantissa per class.
    always_comb begin
        unique case (cls)
            CLS_ZERO: begin
                o_exp = '0;
                o_man = '0;
            end
            CLS_SUBNORM: begin
                o_exp = SGL_EXP_W'(EXP_ADJ + 1) - SGL_EXP_W'(sub_shift);
                o_man = sub_man;
            end
            CLS_SPECIAL: begin
                o_exp = '1;
                o_man = h_man;
            end
            default: begin
                o_exp = SGL_EXP_W'(h_exp) + SGL_EXP_W'(EXP_ADJ);
                o_man = h_man;
            end
        endcase
    end

    // Assemble: sign passes straight through, low mantissa bits are zero.
    always_comb single_out = {sgn, o_exp, o_man, {PAD_W{1'b0}}};

endmodule

// File: rtl/half_to_single_widener.sv
// Module: streaming half-to-single widener. One conversion per cycle,
// no back-pressure. REG_OUT=1 adds a registered stage (one-cycle latency,
// data held when no input is valid); REG_OUT=0 is purely combinational.
// Assumes a synchronous active-low reset.
module half_to_single_widener #(
    parameter int REG_OUT    = 1,
    parameter int HALF_EXP_W = 5,
    parameter int HALF_MAN_W = 10,
    parameter int SGL_EXP_W  = 8,
    parameter int SGL_MAN_W  = 23,
    localparam int HALF_W    = 1 + HALF_EXP_W + HALF_MAN_W,
    localparam int SGL_W     = 1 + SGL_EXP_W + SGL_MAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_bits,
    input  logic              mode,
    output logic              out_valid,
    output logic [SGL_W-1:0]  out_bits
);

    logic [SGL_W-1:0] conv;

    hw_half_widen_core #(
        .HALF_EXP_W (HALF_EXP_W),
        .HALF_MAN_W (HALF_MAN_W),
        .SGL_EXP_W  (SGL_EXP_W),
        .SGL_MAN_W  (SGL_MAN_W)
    ) u_core (
        .mode       (mode),
        .half_in    (in_bits),
        .single_out (conv)
    );

    generate
        if (REG_OUT != 0) begin : g_reg
            // Output stage: capture valid every edge, data only when valid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_bits  <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) out_bits <= conv;
                end
            end
        end else begin : g_comb
            // Pass-through: result follows the input in the same cycle.
            assign out_valid = in_valid;
            assign out_bits  = conv;
        end
    endgenerate

endmodule

// File: rtl/half_to_single_widener_chk.sv
// Checker: cycle properties of the widener, bound into every instance.
// Assumes the default 5/10 and 8/23 field widths.
module half_to_single_widener_chk #(
    parameter int REG_OUT = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_bits,
    input logic        mode,
    input logic        out_valid,
    input logic [31:0] out_bits
);

    generate
        if (REG_OUT != 0) begin : g_seq
            assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_sign_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_bits[31] == $past(in_bits[15]));
            assert_zero_mag_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_bits[14:0] == 15'd0) |=> out_bits[30:0] == 31'd0);
            assert_normal_exp_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_bits[14:10] != 5'd0 && in_bits[14:10] != 5'd31)
                |=> out_bits[30:23] == $past({3'd0, in_bits[14:10]}) + 8'd112);
            assert_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !mode && in_bits[14:10] == 5'd31)
                |=> (out_bits[30:23] == 8'hFF && out_bits[22:13] == $past(in_bits[9:0])
                     && out_bits[12:0] == 13'd0));
            assert_ext_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode && in_bits[14:10] == 5'd31)
                |=> (out_bits[30:23] == 8'h8F && out_bits[22:13] == $past(in_bits[9:0])));
        end else begin : g_imm
            // Same-cycle relations for the combinational variant.
            always_comb begin
                if (rst_n && in_valid) begin
                    assert_sign_copy_R6: assert (out_bits[31] == in_bits[15]);
                    assert_valid_pass_R7: assert (out_valid);
                    if (in_bits[14:0] == 15'd0)
                        assert_zero_mag_R3: assert (out_bits[30:0] == 31'd0);
                    if (!mode && in_bits[14:10] == 5'd31)
                        assert_special_R4: assert (out_bits[30:23] == 8'hFF);
                    if (mode && in_bits[14:10] == 5'd31)
                        assert_ext_top_R5: assert (out_bits[30:23] == 8'h8F);
                end
            end
        end
    endgenerate

endmodule

bind half_to_single_widener half_to_single_widener_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bits   (in_bits),
    .mode      (mode),
    .out_valid (out_valid),
    .out_bits  (out_bits)
);

// File: tb/tb_half_to_single_widener.sv
// Bench: scoreboard. The driver pushes reference results into a queue and
// the monitor pops and compares them as results appear.
module tb_half_to_single_widener;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_bits = 16'd0;
    logic        mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_bits;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit vld_at_edge = 1'b0;
    logic [31:0] last_out = 32'd0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    half_to_single_widener dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .mode      (mode),
        .out_valid (out_valid),
        .out_bits  (out_bits)
    );

    // Reference: step-by-step normalisation, written from the requirements.
    function automatic logic [31:0] ref_widen(input logic md, input logic [15:0] h);
        logic [4:0]  e = h[14:10];
        logic [10:0] mm = {1'b0, h[9:0]};
        int          ee;
        if (e == 0 && h[9:0] == 0) return {h[15], 31'd0};
        if (e == 0) begin
            ee = 113;
            while (!mm[10]) begin
                mm = mm << 1;
                ee = ee - 1;
            end
            return {h[15], 8'(ee), mm[9:0], 13'd0};
        end
        if (e == 5'd31 && !md) return {h[15], 8'hFF, h[9:0], 13'd0};
        return {h[15], 8'(int'(e) + 112), h[9:0], 13'd0};
    endfunction

    function automatic string req_tag(input logic md, input logic [15:0] h);
        if (h[14:0] == 0) return "R3/R6";
        if (h[14:10] == 0) return "R2/R6";
        if (h[14:10] == 5'd31) return md ? "R5/R6" : "R4/R6";
        return "R1/R6";
    endfunction

    task automatic drive(input logic md, input logic [15:0] h);
        @(posedge clk);
        #2;
        in_valid = 1'b1;
        mode     = md;
        in_bits  = h;
        exp_q.push_back(ref_widen(md, h));
        tag_q.push_back(req_tag(md, h));
    endtask

    task automatic bubble();
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        in_bits  = 16'hA5A5;
    endtask

    // Track what out_valid must be after each edge (R7).
    always @(posedge clk) vld_at_edge <= rst_n & in_valid;

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (out_valid !== vld_at_edge) begin
                errors++;
                $display("FAIL R7 out_valid actual %0b expected %0b", out_valid, vld_at_edge);
            end
            if (out_valid) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (out_bits !== e) begin
                    errors++;
                    $display("FAIL %s out_bits actual %08h expected %08h", t, out_bits, e);
                end
                last_out = out_bits;
            end else begin
                checks++;
                if (out_bits !== last_out) begin
                    errors++;
                    $display("FAIL R7 hold out_bits actual %08h expected %08h", out_bits, last_out);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset clears outputs even with in_valid high.
        in_valid = 1'b1;
        in_bits  = 16'h3C00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_bits !== 32'd0) begin
            errors++;
            $display("FAIL R8 reset actual %0b/%08h expected 0/00000000", out_valid, out_bits);
        end
        @(posedge clk);
        #2;
        in_valid = 1'b0;
        rst_n    = 1'b1;
        mon_on   = 1'b1;

        // Named corner cases first, then full sweep in both modes.
        drive(1'b0, 16'h0001);   // R2 smallest subnormal -> 0x33800000
        drive(1'b0, 16'h8000);   // R3 negative zero
        drive(1'b0, 16'h7C00);   // R4 +Inf
        drive(1'b0, 16'hFE01);   // R4 NaN, negative
        drive(1'b1, 16'h7C00);   // R5 top exponent finite
        drive(1'b0, 16'h3C00);   // R1 one
        bubble();
        bubble();
        for (int md = 0; md < 2; md++) begin
            for (int h = 0; h < 65536; h++) begin
                drive(1'(md), 16'(h));
                if ((h % 4096) == 4095) bubble();
            end
        end
        bubble();
        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7 results missing actual %0d expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule